// File: doc/BRIEF.md
# Scaler Source Position Accumulator

This block walks one axis of one plane of a polyphase image scaler. For every destination sample (a pixel along a line, or a line down a frame) it reports which source sample the filter is centred on and which of sixteen filter phases to use. Software programs the source and destination sizes and a signed starting position; the block then derives the step between outputs in hardware and moves a fixed-point position forward by that step each time the filter pipeline asks for the next output.

A start pulse captures the sizes and the start position and launches a restoring divider that settles one quotient bit per clock. While it runs, `busy` is high; when the step is known, `ready` rises and the first output is presented at once. Each `advance` strobe then moves to the next output, and `last` marks the final one. A negative start lets chroma siting sit before the first source sample; the reported index is held inside the source image so such positions reuse the edge sample.

Top module: `scaler_pos_gen`

## Requirements
- R1: Sizes are given as size minus one in 12-bit fields. With S and D the true source and destination sizes, the step is floor(((S * 8192) + floor(D / 2)) / D), that is S/D rounded to nearest with 13 fractional bits, and is shown on `increment` while `ready` is high.
- R2: A step larger than 65535 is reported as 65535, and the saturated value is the one used for stepping.
- R3: After a start pulse, `busy` is high for exactly 26 cycles and `ready` is low; `ready` rises in the cycle `busy` falls. A start pulse while busy restarts the computation with the new inputs.
- R4: The position of output k (k from 0) is start_pos + k * step, with start_pos a 19-bit two's complement value. The source index is floor(position / 8192), clamped to 0 when negative and to S-1 when above it.
- R5: The phase is bits 12 down to 9 of the two's complement position, so a negative position such as -2048 gives phase 12.
- R6: While ready, each cycle with `advance` high and `last` low moves to the next output; without `advance`, index and phase hold.
- R7: `last` is high exactly while ready and the current output is number D-1.
- R8: `advance` has no effect while `busy` is high, and none while `last` is high.
- R9: After reset, `busy`, `ready` and `last` are low and `src_index`, `phase` and `increment` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: capture sizes and start position, compute step |
| src_size_m1 | input | 12 | Source size minus one |
| dst_size_m1 | input | 12 | Destination size minus one |
| start_pos | input | 19 | Signed start position, 13 fractional bits |
| advance | input | 1 | Move to the next output |
| busy | output | 1 | Step computation in progress |
| ready | output | 1 | Step valid, outputs meaningful |
| increment | output | 16 | Computed step, 13 fractional bits |
| src_index | output | 12 | Clamped integer source index |
| phase | output | 4 | Filter phase |
| last | output | 1 | Current output is the final one |

## Verification
Every pairing of source and destination sizes from 1 to 8 is run with start offsets of 0, a quarter sample back and a half sample back, which separates the rounding of the step, the clamping of negative indices at the left edge, the two's complement phase of negative positions and the upper clamp when upscaling. Larger ratios such as 1920 to 1280 and 720 to 1920 exercise long accumulation without drift, while 4096 to 1 checks saturation of the step. Advance strobes held during the computation and issued after the final output show that neither moves the position, and a restart in the middle of a computation shows the second request wins.

// File: rtl/sps_pkg.sv
package sps_pkg;
   localparam int unsigned SPS_SIZE_W  = 12;
   localparam int unsigned SPS_FRAC_W  = 13;
   localparam int unsigned SPS_INC_W   = 16;
   localparam int unsigned SPS_START_W = 19;
   localparam int unsigned SPS_PHASE_W = 4;

   // Number of divider iterations for given field widths.
   function automatic int unsigned sps_div_bits(int unsigned size_w, int unsigned frac_w);
      return size_w + 1 + frac_w;
   endfunction
endpackage

// File: rtl/sps_divider.sv
module sps_divider #(
   parameter int unsigned NUM_W = 26,
   parameter int unsigned DEN_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             busy,
   output logic             valid,
   output logic [NUM_W-1:0] quot
);
   localparam int unsigned CNT_W = $clog2(NUM_W + 1);

   logic [NUM_W-1:0] work_q;
   logic [DEN_W-1:0] rem_q;
   logic [DEN_W-1:0] den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             valid_q;

   logic [DEN_W:0]   rem_sh;
   logic [DEN_W:0]   diff;
   logic             ge;
   logic [DEN_W-1:0] rem_nx;

   always_comb begin
      rem_sh = {rem_q, work_q[NUM_W-1]};
      ge     = rem_sh >= {1'b0, den_q};
      diff   = rem_sh - {1'b0, den_q};
      rem_nx = ge ? diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q  <= '0;
         rem_q   <= '0;
         den_q   <= '0;
         cnt_q   <= '0;
         valid_q <= 1'b0;
      end else if (load) begin
         work_q  <= num;
         rem_q   <= '0;
         den_q   <= den;
         cnt_q   <= CNT_W'(NUM_W);
         valid_q <= 1'b0;
      end else if (cnt_q != '0) begin
         work_q <= {work_q[NUM_W-2:0], ge};
         rem_q  <= rem_nx;
         cnt_q  <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) valid_q <= 1'b1;
      end
   end

   assign busy  = cnt_q != '0;
   assign valid = valid_q;
   assign quot  = work_q;
endmodule

// File: rtl/sps_stepper.sv
module sps_stepper #(
   parameter int unsigned SIZE_W  = 12,
   parameter int unsigned FRAC_W  = 13,
   parameter int unsigned INC_W   = 16,
   parameter int unsigned START_W = 19,
   parameter int unsigned PHASE_W = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic signed [START_W-1:0] start_pos,
   input  logic [SIZE_W-1:0]         src_m1,
   input  logic [SIZE_W-1:0]         dst_m1,
   input  logic [INC_W-1:0]          inc,
   input  logic                      enable,
   input  logic                      advance,
   output logic [SIZE_W-1:0]         index,
   output logic [PHASE_W-1:0]        phase,
   output logic                      last
);
   localparam int unsigned POS_W = SIZE_W + INC_W + 2;

   logic signed [POS_W-1:0] pos_q;
   logic [SIZE_W-1:0]       cnt_q;
   logic [SIZE_W-1:0]       src_q;
   logic [SIZE_W-1:0]       dst_q;
   logic signed [POS_W-1:0] idx_raw;
   logic                    step;

   assign last = enable && (cnt_q == dst_q);
   assign step = enable && advance && !last && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         cnt_q <= '0;
         src_q <= '0;
         dst_q <= '0;
      end else if (load) begin
         pos_q <= POS_W'(start_pos);
         cnt_q <= '0;
         src_q <= src_m1;
         dst_q <= dst_m1;
      end else if (step) begin
         pos_q <= pos_q + $signed({1'b0, inc});
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      idx_raw = pos_q >>> FRAC_W;
      if (idx_raw < 0)
         index = '0;
      else if (idx_raw > $signed(POS_W'({1'b0, src_q})))
         index = src_q;
      else
         index = idx_raw[SIZE_W-1:0];
      phase = pos_q[FRAC_W-1 -: PHASE_W];
   end
endmodule

// File: rtl/scaler_pos_gen.sv
module scaler_pos_gen
   import sps_pkg::*;
#(
   parameter int unsigned SIZE_W  = SPS_SIZE_W,
   parameter int unsigned FRAC_W  = SPS_FRAC_W,
   parameter int unsigned INC_W   = SPS_INC_W,
   parameter int unsigned START_W = SPS_START_W,
   parameter int unsigned PHASE_W = SPS_PHASE_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [SIZE_W-1:0]         src_size_m1,
   input  logic [SIZE_W-1:0]         dst_size_m1,
   input  logic signed [START_W-1:0] start_pos,
   input  logic                      advance,
   output logic                      busy,
   output logic                      ready,
   output logic [INC_W-1:0]          increment,
   output logic [SIZE_W-1:0]         src_index,
   output logic [PHASE_W-1:0]        phase,
   output logic                      last
);
   localparam int unsigned NUM_W = sps_div_bits(SIZE_W, FRAC_W);
   localparam int unsigned DEN_W = SIZE_W + 1;

   if (PHASE_W > FRAC_W) begin : g_bad_phase
      $error("PHASE_W must not exceed FRAC_W");
   end
   if (START_W > SIZE_W + INC_W + 2) begin : g_bad_start
      $error("START_W too wide for the position register");
   end

   logic [DEN_W-1:0] src_full;
   logic [DEN_W-1:0] dst_full;
   logic [NUM_W-1:0] num;
   logic [NUM_W-1:0] quot;
   logic             div_valid;

   assign src_full = {1'b0, src_size_m1} + 1'b1;
   assign dst_full = {1'b0, dst_size_m1} + 1'b1;
   assign num      = {src_full, {FRAC_W{1'b0}}} + NUM_W'(dst_full >> 1);

   sps_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .num   (num),
      .den   (dst_full),
      .busy  (busy),
      .valid (div_valid),
      .quot  (quot)
   );

   if (NUM_W > INC_W) begin : g_sat
      assign increment = (quot > NUM_W'({INC_W{1'b1}})) ? {INC_W{1'b1}} : quot[INC_W-1:0];
   end else begin : g_pass
      assign increment = INC_W'(quot);
   end

   assign ready = div_valid;

   sps_stepper #(
      .SIZE_W(SIZE_W), .FRAC_W(FRAC_W), .INC_W(INC_W),
      .START_W(START_W), .PHASE_W(PHASE_W)
   ) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .start_pos (start_pos),
      .src_m1    (src_size_m1),
      .dst_m1    (dst_size_m1),
      .inc       (increment),
      .enable    (div_valid),
      .advance   (advance),
      .index     (src_index),
      .phase     (phase),
      .last      (last)
   );
endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
   parameter int unsigned SIZE_W  = 12,
   parameter int unsigned PHASE_W = 4,
   parameter int unsigned DIV_N   = 26
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              advance,
   input logic              busy,
   input logic              ready,
   input logic              last,
   input logic [SIZE_W-1:0] src_index,
   input logic [PHASE_W-1:0] phase
);
   localparam int unsigned CW = $clog2(DIV_N + 2);
   logic [CW-1:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bcnt <= '0;
      else if (start) bcnt <= '0;
      else if (busy) bcnt <= bcnt + 1'b1;
   end

   // R3: never busy and ready together
   a_r3_busy_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && ready));
   // R3: start leads to busy, not ready
   a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy && !ready);
   // R3: busy window bounded by the iteration count
   a_r3_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> bcnt < CW'(DIV_N));
   // R6: without advance the outputs hold
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ready && !advance && !start |=> $stable(src_index) && $stable(phase));
   // R6: index never moves backwards on a step
   a_r6_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      ready && !start |=> src_index >= $past(src_index));
   // R8: last holds and freezes outputs
   a_r8_last_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ready && last && !start |=> last && $stable(src_index) && $stable(phase));
   // R7: last only when ready
   a_r7_last_ready: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> ready);
endmodule

bind scaler_pos_gen sps_checker #(
   .SIZE_W(SIZE_W), .PHASE_W(PHASE_W), .DIV_N(SIZE_W + 1 + FRAC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .advance   (advance),
   .busy      (busy),
   .ready     (ready),
   .last      (last),
   .src_index (src_index),
   .phase     (phase)
);

// File: tb/scaler_pos_gen_test.sv
module scaler_pos_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [11:0] src_size_m1 = '0;
   logic [11:0] dst_size_m1 = '0;
   logic signed [18:0] start_pos = '0;
   logic        advance = 1'b0;
   logic        busy, ready, last;
   logic [15:0] increment;
   logic [11:0] src_index;
   logic [3:0]  phase;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   scaler_pos_gen uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_size_m1(src_size_m1), .dst_size_m1(dst_size_m1),
      .start_pos(start_pos), .advance(advance),
      .busy(busy), .ready(ready), .increment(increment),
      .src_index(src_index), .phase(phase), .last(last)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic longint exp_inc(input int s, input int d);
      longint v;
      v = ((longint'(s) << 13) + (d >> 1)) / d;
      return (v > 65535) ? 65535 : v;
   endfunction

   function automatic longint exp_idx(input longint p, input int s);
      longint i;
      i = p >>> 13;
      if (i < 0) return 0;
      if (i > s - 1) return s - 1;
      return i;
   endfunction

   task automatic launch(input int s, input int d, input int st);
      @(negedge clk);
      src_size_m1 = 12'(s - 1);
      dst_size_m1 = 12'(d - 1);
      start_pos   = 19'(st);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_cfg(input int s, input int d, input int st);
      int n;
      longint inc_e, p;
      launch(s, d, st);
      n = 0;
      advance = 1'b1; // R8: held during busy, must not step
      while (busy && n < 100) begin
         chk("R3", "ready during busy", ready, 0);
         n++;
         @(negedge clk);
      end
      advance = 1'b0;
      chk("R3", "busy cycles", n, 26);
      chk("R3", "ready after busy", ready, 1);
      inc_e = exp_inc(s, d);
      chk((inc_e == 65535) ? "R2" : "R1", "increment", increment, inc_e);
      for (int k = 0; k < d; k++) begin
         p = longint'(st) + longint'(k) * inc_e;
         chk("R4", "src_index", src_index, exp_idx(p, s));
         chk("R5", "phase", phase, (p >>> 9) & 15);
         chk("R7", "last", last, (k == d - 1) ? 1 : 0);
         if (k < d - 1) begin
            advance = 1'b1;
            @(negedge clk);
            advance = 1'b0;
            // R6: idle cycle holds
            if (k == 0) begin
               @(negedge clk);
            end
         end
      end
      p = longint'(st) + longint'(d - 1) * inc_e;
      advance = 1'b1;
      @(negedge clk);
      @(negedge clk);
      advance = 1'b0;
      chk("R8", "index after advance at last", src_index, exp_idx(p, s));
      chk("R8", "phase after advance at last", phase, (p >>> 9) & 15);
      chk("R8", "last kept", last, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9", "busy", busy, 0);
      chk("R9", "ready", ready, 0);
      chk("R9", "last", last, 0);
      chk("R9", "src_index", src_index, 0);
      chk("R9", "phase", phase, 0);
      chk("R9", "increment", increment, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int s = 1; s <= 8; s++)
         for (int d = 1; d <= 8; d++) begin
            run_cfg(s, d, 0);
            run_cfg(s, d, -2048);
            run_cfg(s, d, -4096);
         end

      run_cfg(1920, 1280, 0);
      run_cfg(720, 1920, -2048);
      run_cfg(4096, 1, 0);   // R2 saturation
      run_cfg(4096, 4096, 0);
      run_cfg(1, 4096, -4096);

      // R3: restart in the middle of a computation
      launch(100, 7, 0);
      repeat (5) @(negedge clk);
      run_cfg(9, 3, -2048);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule